// File: doc/BRIEF.md
# Clock-Output Enable Register Slave (Two-Wire Bus)

This block is a two-wire serial bus slave that owns a small bank of 8-bit control registers for a clock generator. Each bit of the bank gates one clock output: a 1 lets the output run, a 0 holds it off. The whole bank appears as a parallel vector at the block's edge. After reset every register holds a parameter-defined default, so the clock outputs are in a known state with no bus traffic at all.

The bus lines are oversampled with the system clock. Each line passes through a two-flop synchronizer before edge detection. A transfer begins with a start condition and an address byte. A write sends two header bytes, which are acknowledged and then dropped. Data bytes follow, and they land in register 0, then 1, then 2, and so on. A read streams the registers back from register 0 upward. The block drives the data line only through an open-drain pull-low enable.

Top module: `ckc_i2c_ctl`

## Requirements
- R1: A falling SDA while SCL is high is a start condition and a rising SDA while SCL is high is a stop condition. A start, including one repeated inside a transfer, restarts address decoding. A stop ends the transfer and releases SDA.
- R2: Bytes are sampled MSB first while SCL is high. The slave changes its own SDA drive only while SCL is low.
- R3: Address byte 0xD2 (7-bit address 1101001, R/W bit 0) is acknowledged by pulling SDA low during the ninth SCL pulse.
- R4: Address byte 0xD3 is acknowledged. The slave then returns register 0, 1, 2 and so on, MSB first, for as long as the master acknowledges.
- R5: Any other address byte is not acknowledged. The slave then neither acknowledges nor writes anything until the next start condition.
- R6: In a write, the two bytes after the address (command and count) are acknowledged and discarded. Each following byte is acknowledged and stored in register 0, 1, 2 and so on in order.
- R7: Reset loads every register with its default value, which is 0xFF for all six registers. Output `clk_en[8k+7:8k]` is register k, and a bit of 1 enables its clock output.
- R8: With 6 registers, write data bytes beyond register 5 are acknowledged and discarded, and read bytes beyond register 5 return 0xFF.
- R9: When the master does not acknowledge a read byte, the slave releases SDA. It leaves SDA released through any further SCL pulses until a start or stop condition.
- R10: A write ended by a stop after n data bytes changes only registers 0 to n-1. All later registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| clk_en | output | NREG*8 | Clock-output enable bits, register k at bits 8k+7..8k |

## Verification
Some properties are checked by assertions on every cycle. The slave may start pulling SDA low only while the synchronized SCL is low. It never drives SDA while it is idle. A stop always releases SDA on the next cycle. Register writes stay inside the bank, and the bank holds its defaults straight after reset. Other behaviour shows only in the bench's scenarios. That covers whether the acknowledge decisions are right for each address, the dropping of the two header bytes, the data ordering and the 0xFF padding past the bank. It also covers the effect of a repeated start and the silence that follows a master's not-acknowledge.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,   // ignoring the bus until a start
    PH_ADDR,   // receiving address byte
    PH_CMD,    // first header byte (dropped)
    PH_CNT,    // second header byte (dropped)
    PH_WDATA,  // data bytes to the bank
    PH_READ    // streaming the bank out
  } phase_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/ckc_line_sync.sv
module ckc_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_pipe, sda_pipe;
  logic       scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= 2'b11;
      sda_pipe <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[0], scl_i};
      sda_pipe <= {sda_pipe[0], sda_i};
      scl_q    <= scl_pipe[1];
      sda_q    <= sda_pipe[1];
    end
  end

  assign scl_s     = scl_pipe[1];
  assign sda_s     = sda_pipe[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ckc_reg_bank.sv
module ckc_reg_bank #(
  parameter int NREG = 6,
  parameter int PW   = $clog2(NREG + 1),
  parameter logic [NREG*8-1:0] INIT = {NREG{8'hFF}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [7:0]        wdata,
  output logic [NREG*8-1:0] regs
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[k*8 +: 8] <= INIT[k*8 +: 8];
      else if (we && waddr == PW'(k))
        regs[k*8 +: 8] <= wdata;
    end
  end

  assert_reset_defaults_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> regs == INIT);

  assert_write_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr < PW'(NREG));
endmodule

// File: rtl/ckc_serial_engine.sv
module ckc_serial_engine
  import ckc_pkg::*;
#(
  parameter int          NREG     = 6,
  parameter int          PW       = $clog2(NREG + 1),
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [NREG*8-1:0] regs,
  output logic              we,
  output logic [PW-1:0]     waddr,
  output logic [7:0]        wdata,
  output logic              sda_oe
);
  localparam logic [PW-1:0] LAST = PW'(NREG);

  phase_t      phase;
  logic [3:0]  cnt;
  logic [7:0]  shreg, rbyte, nbyte;
  logic [PW-1:0] ptr;
  logic        mack;
  logic [2:0]  bidx;

  always_comb begin
    nbyte = 8'hFF;
    for (int k = 0; k < NREG; k++)
      if (ptr == PW'(k)) nbyte = regs[k*8 +: 8];
  end

  assign bidx = 3'(4'd7 - cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      rbyte  <= '0;
      ptr    <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      we     <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
    end else begin
      we <= 1'b0;
      if (start_evt) begin
        phase  <= PH_ADDR;
        cnt    <= '0;
        ptr    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            mack <= ~sda_s;
            cnt  <= 4'd9;
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            unique case (phase)
              PH_ADDR:
                if (shreg[7:1] == DEV_ADDR) sda_oe <= 1'b1;
                else                        phase  <= PH_IDLE;
              PH_CMD, PH_CNT: sda_oe <= 1'b1;
              PH_WDATA: begin
                sda_oe <= 1'b1;
                if (ptr < LAST) begin
                  we    <= 1'b1;
                  waddr <= ptr;
                  wdata <= shreg;
                  ptr   <= ptr + 1'b1;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            unique case (phase)
              PH_ADDR:
                if (shreg[0]) begin
                  phase  <= PH_READ;
                  rbyte  <= nbyte;
                  sda_oe <= ~nbyte[7];
                  if (ptr < LAST) ptr <= ptr + 1'b1;
                end else begin
                  phase <= PH_CMD;
                end
              PH_CMD:   phase <= PH_CNT;
              PH_CNT:   phase <= PH_WDATA;
              PH_WDATA: phase <= PH_WDATA;
              default:
                if (mack) begin
                  rbyte  <= nbyte;
                  sda_oe <= ~nbyte[7];
                  if (ptr < LAST) ptr <= ptr + 1'b1;
                end else begin
                  phase <= PH_IDLE;
                end
            endcase
          end else if (cnt != 4'd0 && phase == PH_READ) begin
            sda_oe <= ~rbyte[bidx];
          end
        end
      end
    end
  end

  assert_drive_while_low_R2: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    phase == PH_IDLE |-> !sda_oe);

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);
endmodule

// File: rtl/ckc_i2c_ctl.sv
module ckc_i2c_ctl #(
  parameter int                NREG     = 6,
  parameter logic [6:0]        DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] INIT     = {NREG{8'hFF}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] clk_en
);
  localparam int PW = $clog2(NREG + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic we;
  logic [PW-1:0] waddr;
  logic [7:0] wdata;

  ckc_line_sync u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  ckc_serial_engine #(.NREG(NREG), .PW(PW), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .regs(clk_en),
    .we(we), .waddr(waddr), .wdata(wdata), .sda_oe(sda_oe)
  );

  ckc_reg_bank #(.NREG(NREG), .PW(PW), .INIT(INIT)) u_bank (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata), .regs(clk_en)
  );
endmodule

// File: tb/ckc_i2c_ctl_test.sv
module ckc_i2c_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [47:0] clk_en;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckc_i2c_ctl uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .clk_en(clk_en)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [47:0] act, input logic [47:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H);
    scl_m = 1'b0; hold(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(H);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b1; hold(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(H);
      scl_m = 1'b1; hold(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hold(H);
    scl_m = 1'b1; hold(H/2);
    ack = (sda_bus == 1'b0);
    hold(H/2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H);
      scl_m = 1'b1; hold(H/2);
      b[i] = sda_bus;
      hold(H/2);
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; hold(H);
    scl_m = 1'b1; hold(H);
    scl_m = 1'b0; hold(2);
    sda_m = 1'b1;
  endtask

  task automatic t_reset;
    chk(clk_en, {6{8'hFF}}, "R7 reset defaults");
    chk(48'(sda_oe), 48'h0, "R7 sda released after reset");
  endtask

  task automatic t_full_write;
    logic a;
    bus_start;
    send_byte(8'hD2, a); chk(48'(a), 48'h1, "R3 write address ack");
    send_byte(8'h00, a); chk(48'(a), 48'h1, "R6 command byte ack");
    send_byte(8'h06, a); chk(48'(a), 48'h1, "R6 count byte ack");
    for (int k = 0; k < 6; k++) begin
      send_byte(8'hA1 + 8'(k), a);
      chk(48'(a), 48'h1, "R6 data byte ack");
    end
    bus_stop;
    chk(clk_en, 48'hA6A5A4A3A2A1, "R6 registers in order");
  endtask

  task automatic t_read_all;
    logic a; logic [7:0] b;
    bus_start;
    send_byte(8'hD3, a); chk(48'(a), 48'h1, "R4 read address ack");
    for (int k = 0; k < 6; k++) begin
      recv_byte(1'b1, b);
      chk(48'(b), 48'(8'hA1 + 8'(k)), "R4 R2 read byte MSB first");
    end
    recv_byte(1'b1, b); chk(48'(b), 48'hFF, "R8 read past bank");
    recv_byte(1'b0, b); chk(48'(b), 48'hFF, "R8 read past bank last");
    bus_stop;
  endtask

  task automatic t_overflow_write;
    logic a;
    bus_start;
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h08, a);
    for (int k = 0; k < 8; k++) begin
      send_byte(8'h11 + 8'(k), a);
      if (k >= 6) chk(48'(a), 48'h1, "R8 extra byte acked");
    end
    bus_stop;
    chk(clk_en, 48'h161514131211, "R8 extra bytes discarded");
  endtask

  task automatic t_wrong_addr;
    logic a;
    bus_start;
    send_byte(8'hA0, a); chk(48'(a), 48'h0, "R5 foreign address nack");
    send_byte(8'h00, a); chk(48'(a), 48'h0, "R5 silent after mismatch");
    send_byte(8'h55, a); chk(48'(a), 48'h0, "R5 silent after mismatch");
    bus_stop;
    chk(clk_en, 48'h161514131211, "R5 registers untouched");
  endtask

  task automatic t_partial_write;
    logic a;
    bus_start;
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h02, a);
    send_byte(8'hC0, a); send_byte(8'hC1, a);
    bus_stop;
    chk(clk_en, 48'h16151413C1C0, "R10 only leading registers change");
  endtask

  task automatic t_repeated_start;
    logic a; logic [7:0] b;
    bus_start;
    send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start;
    send_byte(8'hD3, a); chk(48'(a), 48'h1, "R1 repeated start address ack");
    recv_byte(1'b1, b); chk(48'(b), 48'hC0, "R1 read after repeated start");
    recv_byte(1'b0, b); chk(48'(b), 48'hC1, "R1 second byte");
    bus_stop;
    chk(clk_en, 48'h16151413C1C0, "R1 aborted write changed nothing");
  endtask

  task automatic t_master_nack;
    logic a; logic [7:0] b; logic low_seen;
    bus_start;
    send_byte(8'hD3, a);
    recv_byte(1'b0, b); chk(48'(b), 48'hC0, "R9 byte before nack");
    low_seen = 1'b0;
    sda_m = 1'b1;
    for (int i = 0; i < 9; i++) begin
      hold(H);
      scl_m = 1'b1; hold(H/2);
      if (sda_bus == 1'b0) low_seen = 1'b1;
      hold(H/2);
      scl_m = 1'b0;
    end
    chk(48'(low_seen), 48'h0, "R9 SDA released after nack");
    bus_stop;
    bus_start;
    send_byte(8'hD3, a); chk(48'(a), 48'h1, "R9 recovers at next start");
    recv_byte(1'b0, b); chk(48'(b), 48'hC0, "R9 recovered read");
    bus_stop;
  endtask

  initial begin
    hold(4);
    rst = 1'b0;
    hold(4);
    t_reset;
    t_full_write;
    t_read_all;
    t_overflow_write;
    t_wrong_addr;
    t_partial_write;
    t_repeated_start;
    t_master_nack;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule